// File: doc/BRIEF.md
# Legacy I/O Read Idle-Request Redirector

This block sits on the I/O read path leaving a core. Each read is decoded against a small window of legacy idle-level registers placed just above a programmable base address. A read aimed at one of those registers is turned into an internal idle-state request carrying the target C-state. It never reaches the system side, and the requester gets a zero data response. Every other read goes out unchanged on the forward channel.

Two settings control the trapping. An enable switches the redirection on or off. A 3-bit depth limit names the deepest C-state that may still be trapped, so shallower levels can be honoured while deeper ones fall through as ordinary I/O reads. The decision is registered: a read accepted on one clock edge shows up on exactly one output channel from the next cycle on. It stays there until that channel takes it.

Top module: `ioidle_redirect`

## Requirements
- R1: While reset is asserted and right after it, `fwd_valid`, `idle_valid` and `resp_valid` are low and `rd_ready` is high.
- R2: With redirection on and a limit of 7, a read at base+2 yields an idle request with state code 3, base+3 yields code 6, and base+4 yields code 7.
- R3: With redirection off, every accepted read appears on the forward channel with its address unchanged.
- R4: A level read is trapped only when its state code (3, 6 or 7) is less than or equal to `cfg_limit`; otherwise it is forwarded. A limit below 3 traps nothing.
- R5: Reads at any offset from the base other than 2, 3 and 4 are forwarded unchanged.
- R6: A trapped read never raises `fwd_valid`.
- R7: `resp_valid` is high for exactly the one cycle after an idle-request handshake (`idle_valid` and `idle_ready` both high), with `resp_data` equal to zero.
- R8: Each accepted read (`rd_valid` and `rd_ready`) drives exactly one of `fwd_valid` or `idle_valid` in the next cycle, and the two are never high together.
- R9: While the held item's channel is not ready, the item and its payload stay stable and `rd_ready` is low. When that channel is ready, or nothing is held, `rd_ready` is high.
- R10: The level offset is taken modulo 2^ADDR_W, so a base near the top of the address space traps wrapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Redirection enable |
| cfg_base | input | ADDR_W | Base address of the level-register window |
| cfg_limit | input | 3 | Deepest C-state code that may be trapped |
| rd_valid | input | 1 | Incoming I/O read valid |
| rd_addr | input | ADDR_W | Incoming I/O read address |
| rd_ready | output | 1 | Incoming read accepted |
| fwd_valid | output | 1 | Forwarded I/O read valid |
| fwd_addr | output | ADDR_W | Forwarded I/O read address |
| fwd_ready | input | 1 | System side takes forwarded read |
| idle_valid | output | 1 | Idle request valid |
| idle_state | output | 3 | Requested C-state code (3, 6 or 7) |
| idle_ready | input | 1 | Idle request taken |
| resp_valid | output | 1 | Zero data response for a trapped read |
| resp_data | output | DATA_W | Response data, always zero |

## Verification
A response pulse from an idle request taken in one cycle can coincide with a new read being accepted, and with a forwarded read leaving on the other channel in the following cycle. The bench provokes this by alternating trapped and non-trapped addresses at a high valid rate, while toggling both ready inputs at random. A behavioural reference model runs in step with the design and judges every cycle: the zero response, the channel choice, the held payload and `rd_ready` must all match at once.

// File: rtl/ioidle_pkg.sv
package ioidle_pkg;

  localparam int CST_W     = 3;
  localparam int LVL_FIRST = 2;
  localparam int LVL_COUNT = 3;

  typedef logic [CST_W-1:0] cst_t;

  localparam cst_t CST_NONE = 3'd0;
  localparam cst_t CST_C3   = 3'd3;
  localparam cst_t CST_C6   = 3'd6;
  localparam cst_t CST_C7   = 3'd7;

  // level index (offset minus LVL_FIRST) to target state code
  function automatic cst_t lvl_state(input int idx);
    case (idx)
      0:       lvl_state = CST_C3;
      1:       lvl_state = CST_C6;
      2:       lvl_state = CST_C7;
      default: lvl_state = CST_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ioidle_decode.sv
module ioidle_decode
  import ioidle_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  cst_t              limit,
  output logic              trap,
  output cst_t              state
);

  logic [ADDR_W-1:0]    offset;
  logic [LVL_COUNT-1:0] lvl_hit;
  logic [LVL_COUNT-1:0] lvl_ok;
  cst_t                 lvl_code [LVL_COUNT];

  // modulo-2^ADDR_W distance from the window base
  assign offset = addr - base;

  for (genvar g = 0; g < LVL_COUNT; g++) begin : g_lvl
    assign lvl_code[g] = lvl_state(g);
    assign lvl_hit[g]  = (offset == ADDR_W'(LVL_FIRST + g));
    assign lvl_ok[g]   = (lvl_code[g] <= limit);
  end

  always_comb begin
    trap  = 1'b0;
    state = CST_NONE;
    for (int i = 0; i < LVL_COUNT; i++) begin
      if (lvl_hit[i]) begin
        state = lvl_code[i];
        trap  = en & lvl_ok[i];
      end
    end
  end

endmodule

// File: rtl/ioidle_stage.sv
module ioidle_stage
  import ioidle_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_trap,
  input  cst_t              in_state,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              fwd_ready,
  output logic              idle_valid,
  output cst_t              idle_state,
  input  logic              idle_ready
);

  logic              hold_v, hold_v_d;
  logic              hold_idle, hold_idle_d;
  logic [ADDR_W-1:0] hold_addr, hold_addr_d;
  cst_t              hold_st, hold_st_d;
  logic              drain, accept, v_en, pay_en;

  // next-state
  always_comb begin
    drain       = hold_v & (hold_idle ? idle_ready : fwd_ready);
    in_ready    = ~hold_v | drain;
    accept      = in_valid & in_ready;
    v_en        = accept | drain;
    pay_en      = accept;
    hold_v_d    = accept;
    hold_idle_d = in_trap;
    hold_addr_d = in_addr;
    hold_st_d   = in_state;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
    end else if (v_en) begin
      hold_v <= hold_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_idle <= 1'b0;
      hold_addr <= '0;
      hold_st   <= CST_NONE;
    end else if (pay_en) begin
      hold_idle <= hold_idle_d;
      hold_addr <= hold_addr_d;
      hold_st   <= hold_st_d;
    end
  end

  assign fwd_valid  = hold_v & ~hold_idle;
  assign fwd_addr   = hold_addr;
  assign idle_valid = hold_v & hold_idle;
  assign idle_state = hold_st;

  assert_hold_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_valid && !idle_ready |=> idle_valid && $stable(idle_state));
  assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> $countones({fwd_valid, idle_valid}) == 1);

endmodule

// File: rtl/ioidle_resp.sv
module ioidle_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_fire,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);

  logic pulse_q, pulse_d;

  always_comb pulse_d = idle_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign resp_valid = pulse_q;
  assign resp_data  = '0;

endmodule

// File: rtl/ioidle_redirect.sv
module ioidle_redirect
  import ioidle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [2:0]        cfg_limit,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              fwd_ready,
  output logic              idle_valid,
  output logic [2:0]        idle_state,
  input  logic              idle_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);

  logic dec_trap;
  cst_t dec_state;
  logic idle_fire;

  ioidle_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en    (cfg_en),
    .addr  (rd_addr),
    .base  (cfg_base),
    .limit (cfg_limit),
    .trap  (dec_trap),
    .state (dec_state)
  );

  ioidle_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rd_valid),
    .in_ready   (rd_ready),
    .in_trap    (dec_trap),
    .in_state   (dec_state),
    .in_addr    (rd_addr),
    .fwd_valid  (fwd_valid),
    .fwd_addr   (fwd_addr),
    .fwd_ready  (fwd_ready),
    .idle_valid (idle_valid),
    .idle_state (idle_state),
    .idle_ready (idle_ready)
  );

  assign idle_fire = idle_valid & idle_ready;

  ioidle_resp #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_fire  (idle_fire),
    .resp_valid (resp_valid),
    .resp_data  (resp_data)
  );

  assert_resp_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_valid && idle_ready |=> resp_valid);
  assert_resp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(idle_valid && idle_ready));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !cfg_en |=> fwd_valid && fwd_addr == $past(rd_addr));
  assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_valid |-> (idle_state == CST_C3 || idle_state == CST_C6 || idle_state == CST_C7));
  assert_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_valid && !$stable(idle_valid) |-> idle_state <= $past(cfg_limit));
  assert_no_fwd_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && dec_trap |=> !fwd_valid);

endmodule

// File: tb/ioidle_redirect_test.sv
`timescale 1ns/1ps
module ioidle_redirect_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_en, rd_valid, rd_ready, fwd_valid, fwd_ready;
  logic idle_valid, idle_ready, resp_valid;
  logic [AW-1:0] cfg_base, rd_addr, fwd_addr;
  logic [2:0] cfg_limit, idle_state;
  logic [DW-1:0] resp_data;

  ioidle_redirect #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_ready(fwd_ready), .idle_valid(idle_valid), .idle_state(idle_state),
    .idle_ready(idle_ready), .resp_valid(resp_valid), .resp_data(resp_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_hv = 0, m_idle = 0, m_addr = 0, m_st = 0, m_resp = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: advance by one clock edge using inputs present at that edge
  task automatic model_step();
    int drain, acc, off, st;
    drain  = m_hv && (m_idle ? idle_ready : fwd_ready);
    m_resp = (m_hv && m_idle && idle_ready) ? 1 : 0;
    acc    = rd_valid && (!m_hv || drain);
    if (acc) begin
      off = (int'(rd_addr) - int'(cfg_base)) & MASK;
      st  = (off == 2) ? 3 : (off == 3) ? 6 : (off == 4) ? 7 : 0;
      m_hv   = 1;
      m_idle = (cfg_en && st != 0 && st <= int'(cfg_limit)) ? 1 : 0;
      m_addr = int'(rd_addr);
      m_st   = st;
    end else if (drain) begin
      m_hv = 0;
    end
  endtask

  task automatic compare(input string tag);
    int exp_rdy;
    exp_rdy = (!m_hv || (m_idle ? idle_ready : fwd_ready)) ? 1 : 0;
    chk("R9", "rd_ready", rd_ready, exp_rdy);
    chk(tag, "fwd_valid", fwd_valid, (m_hv && !m_idle) ? 1 : 0);
    chk("R8", "idle_valid", idle_valid, (m_hv && m_idle) ? 1 : 0);
    if (m_hv && !m_idle) chk(tag, "fwd_addr", fwd_addr, m_addr);
    if (m_hv && m_idle)  chk("R2", "idle_state", idle_state, m_st);
    chk("R7", "resp_valid", resp_valid, m_resp);
    if (resp_valid) chk("R7", "resp_data", resp_data, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    rst_n = 0; cfg_en = 0; cfg_base = '0; cfg_limit = '0;
    rd_valid = 0; rd_addr = '0; fwd_ready = 0; idle_ready = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "rd_ready", rd_ready, 1);
      chk("R1", "fwd_valid", fwd_valid, 0);
      chk("R1", "idle_valid", idle_valid, 0);
      chk("R1", "resp_valid", resp_valid, 0);
    end
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rd_ready after reset", rd_ready, 1);
    chk("R1", "fwd_valid after reset", fwd_valid, 0);

    for (int cyc = 0; cyc < 1400; cyc++) begin
      @(negedge clk);
      model_step();
      if      (cyc < 200)  tag = "R2";
      else if (cyc < 400)  tag = "R3";
      else if (cyc < 600)  tag = "R4";
      else if (cyc < 800)  tag = "R5";
      else if (cyc < 1000) tag = "R6";
      else                 tag = "R10";
      compare(tag);
      // drive next inputs
      cfg_en    = (cyc < 200 || cyc >= 400) ? 1'b1 : 1'b0;
      cfg_base  = (cyc >= 1000) ? 16'hFFFE : 16'h0410;
      if (cyc >= 400 && cyc < 600) begin
        if (cyc % 20 == 0) cfg_limit = 3'($urandom_range(0, 7));
      end else cfg_limit = 3'd7;
      if (cyc >= 800 && cyc < 1000) begin
        fwd_ready  = 1'b1;
        idle_ready = 1'b1;
        rd_valid   = 1'b1;
      end else begin
        fwd_ready  = ($urandom_range(0, 3) != 0);
        idle_ready = ($urandom_range(0, 3) != 0);
        rd_valid   = ($urandom_range(0, 2) != 0);
      end
      if (cyc >= 600 && cyc < 800 && $urandom_range(0, 1) == 1)
        rd_addr = AW'($urandom);
      else
        rd_addr = cfg_base + AW'($urandom_range(0, 7));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule